// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block runs single read and write cycles on an asynchronous parallel memory bus. The bus carries a 25-bit word address and 16-bit data, and it has active-low output enable and write enable strobes. It also has three active-low chip selects: one for ROM/Flash, one for RAM and one for an external peripheral. An internal requester offers an address, a target code, a read/write flag and write data. The requester gets a one-clock done pulse and, for reads, the captured data. Every strobe edge sits at a fixed clock offset inside a six-clock cycle. This lets slow asynchronous parts run from the internal master clock without a handshake.

In the text below, "phase k" means the k-th clock period after the edge that accepts a request, starting at 0. A cycle covers phases 0 to 5. All bus outputs come straight from flops, so they do not glitch between edges. The pad driver builds the tristate from the separate drive-enable, data-out and data-in signals.

Top module: `extbus_seq`

## Requirements
- R1: After reset, and whenever no cycle is running, all three chip selects, output enable and write enable are high, the drive enable is low, `req_rdy` is high, and `rsp_done` and `rsp_rdata` (0 after reset) do not change.
- R2: A request is accepted on a rising edge where `req_valid` and `req_rdy` are both high. `req_rdy` is then low for exactly phases 0 to 5. A request presented during those phases has no effect on the running cycle, so a request held high starts the next cycle 7 clocks after the previous one.
- R3: Target code 0 drives `bus_cs_n[0]` (ROM/Flash), code 1 drives `bus_cs_n[1]` (RAM) and code 2 drives `bus_cs_n[2]` (peripheral). The selected line is low in phases 0 to 5. Code 3 runs a cycle with no chip select low. At most one chip select is ever low.
- R4: In a read cycle, `bus_oe_n` is low in phases 2, 3 and 4 only, and `bus_we_n` stays high.
- R5: In a write cycle, `bus_we_n` is low in phases 2, 3 and 4 only, and `bus_oe_n` stays high.
- R6: A read captures `bus_din` as sampled at the edge that ends phase 4. The value appears on `rsp_rdata` in phase 5 and holds until the next read capture. Writes leave `rsp_rdata` unchanged.
- R7: `bus_drive` is high in phases 1 to 5 of write cycles only. While a write runs, `bus_dout` carries the accepted write data.
- R8: `rsp_done` is high for exactly one clock, in phase 5 of every cycle, for reads and writes alike.
- R9: `bus_addr` equals the accepted address from phase 0 to phase 5 and does not change during the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal master clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_rdy | output | 1 | Sequencer idle, a request is taken this edge |
| req_addr | input | 25 | Word address of the request |
| req_tgt | input | 2 | Target: 0 ROM/Flash, 1 RAM, 2 peripheral, 3 none |
| req_wr | input | 1 | 1 write, 0 read |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-clock pulse at the last phase of a cycle |
| rsp_rdata | output | 16 | Captured read data |
| bus_addr | output | 25 | External address |
| bus_dout | output | 16 | Data toward the bus |
| bus_din | input | 16 | Data from the bus |
| bus_drive | output | 1 | Data pad output enable, high drives |
| bus_cs_n | output | 3 | Chip selects, active low: [0] ROM/Flash, [1] RAM, [2] peripheral |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |

## Verification
The bench changes `bus_din` on every clock. A capture taken one phase early or late therefore returns a different word than the one expected at the end of phase 4. Reads and writes run against each of the four target codes, which separates chip-select decoding from strobe selection. Requests held high with altered fields during a busy cycle show whether the running cycle stays untouched and whether the 7-clock restart spacing holds. Isolated requests with idle gaps check the return to the all-high idle state.

// File: rtl/extbus_pkg.sv
package extbus_pkg;
   // Target codes carried on req_tgt
   localparam int unsigned TGT_ROM  = 0;
   localparam int unsigned TGT_RAM  = 1;
   localparam int unsigned TGT_PERI = 2;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/extbus_timer.sv
module extbus_timer #(
   parameter int unsigned CYC_LEN = 6,
   localparam int unsigned PW     = extbus_pkg::cnt_width(CYC_LEN)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start_req,
   output logic          busy,
   output logic [PW-1:0] phase,
   output logic          nxt_busy,
   output logic [PW-1:0] nxt_phase,
   output logic          start
);
   localparam logic [PW-1:0] LAST = PW'(CYC_LEN - 1);

   logic run_on;

   always_comb begin
      start     = start_req && !busy;
      run_on    = busy && (phase != LAST);
      nxt_busy  = start || run_on;
      nxt_phase = run_on ? phase + 1'b1 : '0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         busy  <= 1'b0;
         phase <= '0;
      end else begin
         busy  <= nxt_busy;
         phase <= nxt_phase;
      end
   end
endmodule

// File: rtl/extbus_strobes.sv
module extbus_strobes #(
   parameter int unsigned N_SEL   = 3,
   parameter int unsigned SEL_W   = 2,
   parameter int unsigned PW      = 3,
   parameter int unsigned STB_ON  = 2,
   parameter int unsigned STB_OFF = 5,
   parameter int unsigned DRV_ON  = 1,
   parameter int unsigned CYC_LEN = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             nxt_busy,
   input  logic [PW-1:0]    nxt_phase,
   input  logic             nxt_wr,
   input  logic [SEL_W-1:0] nxt_tgt,
   output logic [N_SEL-1:0] cs_n,
   output logic             oe_n,
   output logic             we_n,
   output logic             drive,
   output logic             done
);
   logic in_stb, in_drv, at_end;

   always_comb begin
      in_stb = (nxt_phase >= PW'(STB_ON)) && (nxt_phase < PW'(STB_OFF));
      in_drv = (nxt_phase >= PW'(DRV_ON)) && (nxt_phase < PW'(CYC_LEN));
      at_end = (nxt_phase == PW'(CYC_LEN - 1));
   end

   for (genvar i = 0; i < N_SEL; i++) begin : g_cs
      always_ff @(posedge clk) begin
         if (rst) cs_n[i] <= 1'b1;
         else     cs_n[i] <= !(nxt_busy && (nxt_tgt == SEL_W'(i)));
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         oe_n  <= 1'b1;
         we_n  <= 1'b1;
         drive <= 1'b0;
         done  <= 1'b0;
      end else begin
         oe_n  <= !(nxt_busy && !nxt_wr && in_stb);
         we_n  <= !(nxt_busy &&  nxt_wr && in_stb);
         drive <= nxt_busy && nxt_wr && in_drv;
         done  <= nxt_busy && at_end;
      end
   end
endmodule

// File: rtl/extbus_datapath.sv
module extbus_datapath #(
   parameter int unsigned AW    = 25,
   parameter int unsigned DW    = 16,
   parameter int unsigned SEL_W = 2,
   parameter int unsigned PW    = 3,
   parameter int unsigned CAP_PH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic             busy,
   input  logic [PW-1:0]    phase,
   input  logic [AW-1:0]    in_addr,
   input  logic [SEL_W-1:0] in_tgt,
   input  logic             in_wr,
   input  logic [DW-1:0]    in_wdata,
   input  logic [DW-1:0]    din,
   output logic [AW-1:0]    addr_q,
   output logic [SEL_W-1:0] tgt_q,
   output logic             wr_q,
   output logic [DW-1:0]    wdata_q,
   output logic [DW-1:0]    rdata_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q  <= '0;
         tgt_q   <= '0;
         wr_q    <= 1'b0;
         wdata_q <= '0;
         rdata_q <= '0;
      end else begin
         if (start) begin
            addr_q  <= in_addr;
            tgt_q   <= in_tgt;
            wr_q    <= in_wr;
            wdata_q <= in_wdata;
         end
         if (busy && !wr_q && (phase == PW'(CAP_PH)))
            rdata_q <= din;
      end
   end
endmodule

// File: rtl/extbus_seq.sv
module extbus_seq #(
   parameter int unsigned AW      = 25,
   parameter int unsigned DW      = 16,
   parameter int unsigned N_SEL   = 3,
   parameter int unsigned STB_ON  = 2,
   parameter int unsigned STB_OFF = 5,
   parameter int unsigned DRV_ON  = 1,
   parameter int unsigned CYC_LEN = 6,
   localparam int unsigned SEL_W  = extbus_pkg::cnt_width(N_SEL + 1),
   localparam int unsigned PW     = extbus_pkg::cnt_width(CYC_LEN)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req_valid,
   output logic             req_rdy,
   input  logic [AW-1:0]    req_addr,
   input  logic [SEL_W-1:0] req_tgt,
   input  logic             req_wr,
   input  logic [DW-1:0]    req_wdata,
   output logic             rsp_done,
   output logic [DW-1:0]    rsp_rdata,
   output logic [AW-1:0]    bus_addr,
   output logic [DW-1:0]    bus_dout,
   input  logic [DW-1:0]    bus_din,
   output logic             bus_drive,
   output logic [N_SEL-1:0] bus_cs_n,
   output logic             bus_oe_n,
   output logic             bus_we_n
);
   if (STB_ON < 1 || STB_OFF <= STB_ON) begin : g_bad_stb
      $error("strobe window must open after phase 0 and be non-empty");
   end
   if (CYC_LEN <= STB_OFF) begin : g_bad_len
      $error("cycle must outlast the strobe release");
   end
   if (DRV_ON >= STB_ON) begin : g_bad_drv
      $error("write data must be driven before the strobe falls");
   end

   logic             busy, nxt_busy, start;
   logic [PW-1:0]    phase, nxt_phase;
   logic [SEL_W-1:0] tgt_q, nxt_tgt;
   logic             wr_q, nxt_wr;

   extbus_timer #(.CYC_LEN(CYC_LEN)) u_timer (
      .clk(clk), .rst(rst), .start_req(req_valid),
      .busy(busy), .phase(phase),
      .nxt_busy(nxt_busy), .nxt_phase(nxt_phase), .start(start)
   );

   extbus_datapath #(
      .AW(AW), .DW(DW), .SEL_W(SEL_W), .PW(PW), .CAP_PH(STB_OFF - 1)
   ) u_dp (
      .clk(clk), .rst(rst), .start(start), .busy(busy), .phase(phase),
      .in_addr(req_addr), .in_tgt(req_tgt), .in_wr(req_wr),
      .in_wdata(req_wdata), .din(bus_din),
      .addr_q(bus_addr), .tgt_q(tgt_q), .wr_q(wr_q),
      .wdata_q(bus_dout), .rdata_q(rsp_rdata)
   );

   always_comb begin
      nxt_tgt = start ? req_tgt : tgt_q;
      nxt_wr  = start ? req_wr  : wr_q;
      req_rdy = !busy;
   end

   extbus_strobes #(
      .N_SEL(N_SEL), .SEL_W(SEL_W), .PW(PW), .STB_ON(STB_ON),
      .STB_OFF(STB_OFF), .DRV_ON(DRV_ON), .CYC_LEN(CYC_LEN)
   ) u_stb (
      .clk(clk), .rst(rst), .nxt_busy(nxt_busy), .nxt_phase(nxt_phase),
      .nxt_wr(nxt_wr), .nxt_tgt(nxt_tgt),
      .cs_n(bus_cs_n), .oe_n(bus_oe_n), .we_n(bus_we_n),
      .drive(bus_drive), .done(rsp_done)
   );
endmodule

// File: rtl/extbus_seq_chk.sv
module extbus_seq_chk #(
   parameter int unsigned AW    = 25,
   parameter int unsigned DW    = 16,
   parameter int unsigned N_SEL = 3
) (
   input logic             clk,
   input logic             rst,
   input logic             req_valid,
   input logic             req_rdy,
   input logic             rsp_done,
   input logic [DW-1:0]    rsp_rdata,
   input logic [AW-1:0]    bus_addr,
   input logic             bus_drive,
   input logic [N_SEL-1:0] bus_cs_n,
   input logic             bus_oe_n,
   input logic             bus_we_n
);
   // R3
   cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(~bus_cs_n));
   // R4
   oe_we_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(!bus_oe_n && !bus_we_n));
   // R7
   no_drive_on_read_chk: assert property (@(posedge clk) disable iff (rst)
      bus_drive |-> bus_oe_n);
   // R2
   accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_rdy) |=> !req_rdy);
   // R8
   done_then_idle_chk: assert property (@(posedge clk) disable iff (rst)
      rsp_done |=> req_rdy);
   // R9
   addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!req_rdy && $past(!req_rdy)) |-> $stable(bus_addr));
   // R6
   rdata_on_done_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(rsp_rdata) |-> rsp_done);
   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (req_rdy && !rsp_done) |-> (bus_oe_n && bus_we_n && !bus_drive));
endmodule

bind extbus_seq extbus_seq_chk #(.AW(AW), .DW(DW), .N_SEL(N_SEL)) u_chk (
   .clk(clk), .rst(rst), .req_valid(req_valid), .req_rdy(req_rdy),
   .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
   .bus_drive(bus_drive), .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n),
   .bus_we_n(bus_we_n)
);

// File: tb/tb_extbus_seq.sv
module tb_extbus_seq;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic        req_rdy;
   logic [24:0] req_addr = '0;
   logic [1:0]  req_tgt = '0;
   logic        req_wr = 1'b0;
   logic [15:0] req_wdata = '0;
   logic        rsp_done;
   logic [15:0] rsp_rdata;
   logic [24:0] bus_addr;
   logic [15:0] bus_dout;
   logic [15:0] bus_din = '0;
   logic        bus_drive;
   logic [2:0]  bus_cs_n;
   logic        bus_oe_n, bus_we_n;

   int total = 0, bad = 0, cyc = 0;

   always #2 clk = ~clk;

   extbus_seq dut (.*);

   // reference model state
   bit          m_busy = 0;
   int          m_ph = 0;
   logic [24:0] m_addr = '0;
   int          m_tgt = 0;
   bit          m_wr = 0;
   logic [15:0] m_wdata = '0, m_rdata = '0;
   bit          armed = 0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rst) begin
         m_busy = 0; m_ph = 0; m_addr = '0; m_tgt = 0; m_wr = 0;
         m_wdata = '0; m_rdata = '0; armed = 1;
      end else if (m_busy) begin
         if (m_ph == 4 && !m_wr) m_rdata = bus_din;
         if (m_ph == 5) begin m_busy = 0; m_ph = 0; end
         else m_ph = m_ph + 1;
      end else if (req_valid) begin
         m_busy = 1; m_ph = 0; m_addr = req_addr; m_tgt = int'(req_tgt);
         m_wr = req_wr; m_wdata = req_wdata;
      end
   end

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s cycle %0d: got %h expected %h", tag, cyc, got, exp);
      end
   endtask

   always @(negedge clk) begin
      if (armed) begin
         bit stb, idle;
         logic [2:0] cs_exp;
         idle = !m_busy;
         stb  = m_busy && m_ph >= 2 && m_ph <= 4;
         for (int i = 0; i < 3; i++) cs_exp[i] = !(m_busy && m_tgt == i);
         check("R2 ready", 32'(req_rdy), 32'(!m_busy));
         check(idle ? "R1 chip selects" : "R3 chip selects",
               32'(bus_cs_n), 32'(cs_exp));
         check(idle ? "R1 oe" : "R4 oe", 32'(bus_oe_n), 32'(!(stb && !m_wr)));
         check(idle ? "R1 we" : "R5 we", 32'(bus_we_n), 32'(!(stb && m_wr)));
         check("R7 drive", 32'(bus_drive),
               32'(m_busy && m_wr && m_ph >= 1));
         if (m_busy && m_wr) check("R7 dout", 32'(bus_dout), 32'(m_wdata));
         check("R8 done", 32'(rsp_done), 32'(m_busy && m_ph == 5));
         check("R6 rdata", 32'(rsp_rdata), 32'(m_rdata));
         if (m_busy) check("R9 addr", 32'(bus_addr), 32'(m_addr));
      end
      // bus data changes every clock so capture timing is visible
      bus_din <= 16'(cyc * 16'h9E37 + 16'h1234);
   end

   task automatic issue(logic [24:0] a, logic [1:0] t, bit w,
                        logic [15:0] d, bit hold_junk);
      @(negedge clk);
      req_valid = 1; req_addr = a; req_tgt = t; req_wr = w; req_wdata = d;
      while (!req_rdy) @(negedge clk);
      @(negedge clk);
      if (hold_junk) begin
         // R2: fields change while busy; the running cycle must not follow
         req_addr = ~a; req_tgt = t + 2'd1; req_wr = !w; req_wdata = ~d;
         repeat (3) @(negedge clk);
      end
      req_valid = 0;
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (2000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: got hung expected finish");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst = 0;
      repeat (3) @(negedge clk);
      issue(25'h0000123, 2'd0, 0, 16'h0, 0);           // R4 ROM read
      repeat (4) @(negedge clk);
      issue(25'h0ABCDEF, 2'd1, 1, 16'hBEEF, 0);        // R5 RAM write
      repeat (8) @(negedge clk);
      issue(25'h1FFFFFF, 2'd2, 0, 16'h0, 0);           // R3 peripheral read
      repeat (8) @(negedge clk);
      issue(25'h0000001, 2'd3, 1, 16'hFFFF, 0);        // R3 no select
      repeat (8) @(negedge clk);
      issue(25'h1555555, 2'd1, 0, 16'h0, 1);           // R2 junk while busy
      // R2 back-to-back: held request restarts after 7 clocks
      @(negedge clk);
      req_valid = 1; req_addr = 25'h0F0F0F0; req_tgt = 2'd0; req_wr = 0;
      repeat (20) @(negedge clk);
      req_wr = 1; req_tgt = 2'd2; req_wdata = 16'h5A5A;
      repeat (14) @(negedge clk);
      req_valid = 0;
      repeat (10) @(negedge clk);
      issue(25'h0000000, 2'd1, 1, 16'h0000, 0);        // R6 write keeps rdata
      repeat (10) @(negedge clk);
      finish_run();
   end
endmodule